// File: doc/BRIEF.md
# CAN Frame Bit Serializer

This block turns a description of one CAN data or remote frame into the serial bit sequence a transmitter puts on the bus. It takes a format select (11-bit or 29-bit identifier), a remote-request flag, the identifier, a 4-bit length code, up to eight payload bytes and a 15-bit CRC that has already been computed elsewhere. It drives the start-of-frame bit, the header, the payload, the CRC and the recessive trailer, and it inserts stuff bits where the protocol requires them.

Bit timing lives outside the block. A one-cycle `bit_tick` moves the output to the next bit, and a separate one-cycle `sample_tick` marks the point in the bit where the bus level `bus_in` is compared with what is being driven. If the node drives recessive inside the arbitration span but sees dominant, it has lost arbitration. It then releases the bus to recessive at once and ends the frame. A frame starts only when the block is idle and the surrounding logic reports the bus quiet, which means no error frame and no interframe gap is in progress. Completion is reported by `busy` falling together with a one-cycle `done`.

Top module: `frame_bit_serializer`

## Requirements
- R1: After reset, `bus_out` is 1 (recessive) and `busy`, `done` and `arb_lost` are 0.
- R2: `start` is accepted only on a cycle where `busy` is 0 and `bus_quiet` is 1. `busy` is 1 in the next cycle. All `frm_*` inputs are captured at acceptance, so later changes do not affect the frame. A `start` on any other cycle is ignored.
- R3: With `frm_ext`=0 the unstuffed sequence is a dominant 0 for start-of-frame, then `frm_id[10:0]` MSB first, then the remote flag, then two 0 bits, then `frm_len` MSB first.
- R4: With `frm_ext`=1 the unstuffed sequence is 0, then `frm_id[28:18]`, then two 1 bits, then `frm_id[17:0]`, then the remote flag, then two 0 bits, then `frm_len`, each field MSB first.
- R5: After the length, the payload is sent MSB first, starting with byte 0 in `frm_data[63:56]`. The number of bytes is `frm_len` limited to 8. No payload is sent when `frm_remote`=1, whatever the length is. The 15-bit CRC follows, MSB first.
- R6: From start-of-frame through the last CRC bit, every run of five equal transmitted bits is followed by one bit of the opposite level. Inserted bits count toward the next run. This can add one bit after the final CRC bit.
- R7: After the stuffed section, 13 recessive bits are sent without stuffing. On the next `bit_tick`, `done` pulses for exactly one cycle and `busy` falls.
- R8: `bus_out` changes only in the cycle after a `bit_tick`, and each `bit_tick` while busy advances by exactly one bit.
- R9: Arbitration is lost when a `sample_tick` arrives while `bus_out`=1 and `bus_in`=0, inside positions 1 to 12 after start-of-frame for 11-bit frames or 1 to 32 for 29-bit frames (stuff bits counted as positions). In the next cycle `bus_out` is 1, `busy` is 0 and `done` pulses. `arb_lost` then stays 1 until the next accepted start.
- R10: A dominant bus outside the arbitration span, or while the block drives dominant, has no effect on the output sequence or on `arb_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to send the described frame |
| bus_quiet | input | 1 | 1 when no error frame or interframe gap is in progress |
| frm_ext | input | 1 | 1 selects the 29-bit identifier layout |
| frm_remote | input | 1 | Remote request flag |
| frm_id | input | 29 | Identifier (bits 10:0 used in 11-bit layout) |
| frm_len | input | 4 | Length code |
| frm_data | input | 64 | Payload, byte 0 in bits 63:56 |
| frm_crc | input | 15 | Precomputed CRC |
| bit_tick | input | 1 | One-cycle strobe advancing to the next bit |
| sample_tick | input | 1 | One-cycle strobe at the bus sample point |
| bus_in | input | 1 | Sampled bus level, 0 dominant |
| bus_out | output | 1 | Transmit level, 0 dominant |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame ends |
| arb_lost | output | 1 | Last frame ended by lost arbitration |

## Verification
The properties assume that `bit_tick` and `sample_tick` are single-cycle strobes that never fall in the same cycle, and that `start` is sampled as a level. The stimulus places the two strobes two cycles apart within a four-cycle bit period. `bus_in` is the wired AND of `bus_out` and a dominant override, so the bus can never read recessive while the block drives dominant. The override is applied only between a bit strobe and the following sample strobe, which keeps each forced level confined to whole bits.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int ID_W      = 29;
    localparam int BASE_ID_W = 11;
    localparam int LEN_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int CRC_W     = 15;
    localparam int STUFF_RUN = 5;
    localparam int TRAIL_LEN = 13;
    localparam int BASE_ARB  = 12;
    localparam int EXT_ARB   = 32;

    // start bit + identifier + two substitute/extension bits + remote + two reserved + length
    localparam int HDR_MAX   = 1 + ID_W + 2 + 1 + 2 + LEN_W;
    localparam int BODY_MAX  = HDR_MAX + DATA_W + CRC_W;
    localparam int BODY_W    = $clog2(BODY_MAX + 1);
    localparam int RUN_W     = $clog2(STUFF_RUN + 1);
    localparam int TRAIL_W   = $clog2(TRAIL_LEN + 1);
    localparam int POS_W     = $clog2(EXT_ARB + 2) + 1;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_BODY,
        SER_TRAIL
    } ser_state_e;

    typedef struct packed {
        logic              ext;
        logic              remote;
        logic [ID_W-1:0]   ident;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] payload;
        logic [CRC_W-1:0]  crc;
    } frame_desc_t;

    function automatic logic [LEN_W-1:0] payload_bytes(logic remote, logic [LEN_W-1:0] len);
        if (remote)
            return '0;
        else if (len > LEN_W'(MAX_BYTES))
            return LEN_W'(MAX_BYTES);
        else
            return len;
    endfunction

    function automatic logic [POS_W-1:0] arb_span(logic ext);
        return ext ? POS_W'(EXT_ARB) : POS_W'(BASE_ARB);
    endfunction

endpackage

// File: rtl/fbs_frame_pack.sv
module fbs_frame_pack
    import fbs_pkg::*;
(
    input  frame_desc_t         desc,
    output logic [BODY_MAX-1:0] body_bits,
    output logic [BODY_W-1:0]   body_len
);

    // Left-justified unstuffed sequence; first bit to send sits in the MSB.
    always_comb begin
        int n;
        int nbits;
        body_bits = '0;
        n = 0;
        nbits = 8 * int'(payload_bytes(desc.remote, desc.len));

        body_bits[BODY_MAX-1-n] = 1'b0;
        n = n + 1;

        if (desc.ext) begin
            for (int i = ID_W - 1; i >= ID_W - BASE_ID_W; i--) begin
                body_bits[BODY_MAX-1-n] = desc.ident[i];
                n = n + 1;
            end
            body_bits[BODY_MAX-1-n] = 1'b1;
            n = n + 1;
            body_bits[BODY_MAX-1-n] = 1'b1;
            n = n + 1;
            for (int i = ID_W - BASE_ID_W - 1; i >= 0; i--) begin
                body_bits[BODY_MAX-1-n] = desc.ident[i];
                n = n + 1;
            end
        end else begin
            for (int i = BASE_ID_W - 1; i >= 0; i--) begin
                body_bits[BODY_MAX-1-n] = desc.ident[i];
                n = n + 1;
            end
        end

        body_bits[BODY_MAX-1-n] = desc.remote;
        n = n + 1;
        body_bits[BODY_MAX-1-n] = 1'b0;
        n = n + 1;
        body_bits[BODY_MAX-1-n] = 1'b0;
        n = n + 1;

        for (int i = LEN_W - 1; i >= 0; i--) begin
            body_bits[BODY_MAX-1-n] = desc.len[i];
            n = n + 1;
        end

        for (int j = DATA_W - 1; j >= 0; j--) begin
            if ((DATA_W - 1 - j) < nbits) begin
                body_bits[BODY_MAX-1-n] = desc.payload[j];
                n = n + 1;
            end
        end

        for (int i = CRC_W - 1; i >= 0; i--) begin
            body_bits[BODY_MAX-1-n] = desc.crc[i];
            n = n + 1;
        end

        body_len = BODY_W'(n);
    end

endmodule

// File: rtl/fbs_sequencer.sv
module fbs_sequencer
    import fbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [BODY_MAX-1:0] body_bits,
    input  logic [BODY_W-1:0]   body_len,
    input  logic [POS_W-1:0]    arb_last,
    input  logic                bit_tick,
    input  logic                abort,
    output logic                tx_bit,
    output logic                busy,
    output logic                done,
    output logic                in_arb
);

    ser_state_e          state;
    logic [BODY_MAX-1:0] shreg;
    logic [BODY_W-1:0]   left;
    logic [RUN_W-1:0]    run;
    logic                last_lvl;
    logic [TRAIL_W-1:0]  trail_n;
    logic [POS_W-1:0]    sent;
    logic [POS_W-1:0]    arb_hi;
    logic                head_bit;

    assign head_bit = shreg[BODY_MAX-1];
    assign busy     = (state != SER_IDLE);
    // sent counts emitted bits; bit position p (start bit = 0) is on the bus while sent == p + 1
    assign in_arb   = (state == SER_BODY) && (sent > POS_W'(1)) && (sent <= arb_hi + POS_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SER_IDLE;
            shreg    <= '0;
            left     <= '0;
            run      <= '0;
            last_lvl <= 1'b1;
            trail_n  <= '0;
            sent     <= '0;
            arb_hi   <= '0;
            tx_bit   <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SER_IDLE: begin
                    tx_bit <= 1'b1;
                    if (accept) begin
                        state    <= SER_BODY;
                        shreg    <= body_bits;
                        left     <= body_len;
                        run      <= '0;
                        last_lvl <= 1'b1;
                        sent     <= '0;
                        arb_hi   <= arb_last;
                    end
                end
                SER_BODY: begin
                    if (abort) begin
                        state  <= SER_IDLE;
                        tx_bit <= 1'b1;
                        done   <= 1'b1;
                    end else if (bit_tick) begin
                        if (sent != '1)
                            sent <= sent + POS_W'(1);
                        if (run == RUN_W'(STUFF_RUN)) begin
                            tx_bit   <= ~last_lvl;
                            last_lvl <= ~last_lvl;
                            run      <= RUN_W'(1);
                        end else if (left != '0) begin
                            tx_bit   <= head_bit;
                            shreg    <= {shreg[BODY_MAX-2:0], 1'b0};
                            left     <= left - BODY_W'(1);
                            last_lvl <= head_bit;
                            run      <= (head_bit == last_lvl) ? run + RUN_W'(1) : RUN_W'(1);
                        end else begin
                            state   <= SER_TRAIL;
                            tx_bit  <= 1'b1;
                            trail_n <= TRAIL_W'(1);
                        end
                    end
                end
                SER_TRAIL: begin
                    if (bit_tick) begin
                        tx_bit <= 1'b1;
                        if (trail_n == TRAIL_W'(TRAIL_LEN)) begin
                            state <= SER_IDLE;
                            done  <= 1'b1;
                        end else begin
                            trail_n <= trail_n + TRAIL_W'(1);
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fbs_arb_watch.sv
module fbs_arb_watch (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic sample_tick,
    input  logic in_arb,
    input  logic tx_bit,
    input  logic rx_bit,
    output logic abort,
    output logic lost
);

    assign abort = sample_tick & in_arb & tx_bit & ~rx_bit;

    always_ff @(posedge clk) begin
        if (rst)
            lost <= 1'b0;
        else if (accept)
            lost <= 1'b0;
        else if (abort)
            lost <= 1'b1;
    end

endmodule

// File: rtl/frame_bit_serializer.sv
module frame_bit_serializer
    import fbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bus_quiet,
    input  logic              frm_ext,
    input  logic              frm_remote,
    input  logic [ID_W-1:0]   frm_id,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [DATA_W-1:0] frm_data,
    input  logic [CRC_W-1:0]  frm_crc,
    input  logic              bit_tick,
    input  logic              sample_tick,
    input  logic              bus_in,
    output logic              bus_out,
    output logic              busy,
    output logic              done,
    output logic              arb_lost
);

    frame_desc_t         desc;
    logic [BODY_MAX-1:0] body_bits;
    logic [BODY_W-1:0]   body_len;
    logic                accept;
    logic                abort;
    logic                in_arb;

    always_comb begin
        desc.ext     = frm_ext;
        desc.remote  = frm_remote;
        desc.ident   = frm_id;
        desc.len     = frm_len;
        desc.payload = frm_data;
        desc.crc     = frm_crc;
    end

    assign accept = start & bus_quiet & ~busy;

    fbs_frame_pack u_pack (
        .desc      (desc),
        .body_bits (body_bits),
        .body_len  (body_len)
    );

    fbs_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .body_bits (body_bits),
        .body_len  (body_len),
        .arb_last  (arb_span(frm_ext)),
        .bit_tick  (bit_tick),
        .abort     (abort),
        .tx_bit    (bus_out),
        .busy      (busy),
        .done      (done),
        .in_arb    (in_arb)
    );

    fbs_arb_watch u_arb (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .sample_tick (sample_tick),
        .in_arb      (in_arb),
        .tx_bit      (bus_out),
        .rx_bit      (bus_in),
        .abort       (abort),
        .lost        (arb_lost)
    );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic bus_quiet,
    input logic bit_tick,
    input logic bus_out,
    input logic busy,
    input logic done,
    input logic arb_lost
);

    // R1
    idle_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bus_out);

    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (start && bus_quiet && !busy) |=> busy);

    // R2
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(start && bus_quiet)) |=> !busy);

    // R7
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(bus_out));

    // R9
    lost_releases_bus_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> bus_out);

    // R9
    lost_ends_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> (done && !busy));

endmodule

bind frame_bit_serializer fbs_checker u_fbs_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bus_quiet (bus_quiet),
    .bit_tick  (bit_tick),
    .bus_out   (bus_out),
    .busy      (busy),
    .done      (done),
    .arb_lost  (arb_lost)
);

// File: tb/frame_bit_serializer_test.sv
module frame_bit_serializer_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bus_quiet = 1'b1;
    logic        frm_ext = 1'b0;
    logic        frm_remote = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_len = '0;
    logic [63:0] frm_data = '0;
    logic [14:0] frm_crc = '0;
    logic        bit_tick = 1'b0;
    logic        sample_tick = 1'b0;
    logic        force_dom = 1'b0;
    logic        bus_in;
    logic        bus_out;
    logic        busy;
    logic        done;
    logic        arb_lost;

    int    n_chk = 0;
    int    n_fail = 0;
    int    bits_seen = 0;
    int    done_cnt = 0;
    bit    sb_on = 1'b1;
    bit    exp_q[$];
    string cur_tag = "R1";

    always #2 clk = ~clk;

    assign bus_in = bus_out & ~force_dom;

    frame_bit_serializer uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .bus_quiet   (bus_quiet),
        .frm_ext     (frm_ext),
        .frm_remote  (frm_remote),
        .frm_id      (frm_id),
        .frm_len     (frm_len),
        .frm_data    (frm_data),
        .frm_crc     (frm_crc),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .bus_in      (bus_in),
        .bus_out     (bus_out),
        .busy        (busy),
        .done        (done),
        .arb_lost    (arb_lost)
    );

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Scoreboard driver side: expected stuffed stream followed by the trailer
    task automatic push_frame(bit ext, bit rem, logic [28:0] id, logic [3:0] len,
                              logic [63:0] data, logic [14:0] crc);
        bit raw[$];
        int nbytes;
        int run;
        bit last;
        raw.push_back(1'b0);
        if (ext) begin
            for (int i = 28; i >= 18; i--) raw.push_back(id[i]);
            raw.push_back(1'b1);
            raw.push_back(1'b1);
            for (int i = 17; i >= 0; i--) raw.push_back(id[i]);
        end else begin
            for (int i = 10; i >= 0; i--) raw.push_back(id[i]);
        end
        raw.push_back(rem);
        raw.push_back(1'b0);
        raw.push_back(1'b0);
        for (int i = 3; i >= 0; i--) raw.push_back(len[i]);
        nbytes = rem ? 0 : ((len > 4'd8) ? 8 : int'(len));
        for (int b = 0; b < nbytes; b++)
            for (int k = 7; k >= 0; k--) raw.push_back(data[56 - 8*b + k]);
        for (int i = 14; i >= 0; i--) raw.push_back(crc[i]);
        run = 0;
        last = 1'b1;
        foreach (raw[i]) begin
            exp_q.push_back(raw[i]);
            run = (raw[i] == last) ? run + 1 : 1;
            last = raw[i];
            if (run == 5) begin
                exp_q.push_back(~last);
                last = ~last;
                run = 1;
            end
        end
        for (int i = 0; i < 13; i++) exp_q.push_back(1'b1);
    endtask

    task automatic launch(bit use_sb, bit ext, bit rem, logic [28:0] id, logic [3:0] len,
                          logic [63:0] data, logic [14:0] crc);
        while (busy) step();
        exp_q.delete();
        sb_on = use_sb;
        if (use_sb) push_frame(ext, rem, id, len, data, crc);
        bits_seen = 0;
        frm_ext = ext;
        frm_remote = rem;
        frm_id = id;
        frm_len = len;
        frm_data = data;
        frm_crc = crc;
        start = 1'b1;
        step();
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after accept", 32'(busy), 1);
        check(arb_lost === 1'b0, "R9", "lost flag cleared on accept", 32'(arb_lost), 0);
        // R2: inputs changed after acceptance must not alter the frame
        frm_ext = ~ext;
        frm_remote = ~rem;
        frm_id = ~id;
        frm_len = ~len;
        frm_data = ~data;
        frm_crc = ~crc;
    endtask

    task automatic finish_frame();
        int d0;
        d0 = done_cnt;
        while (busy || exp_q.size() != 0) step();
        repeat (3) step();
        check(done_cnt - d0 <= 1, "R7", "single done pulse", 32'(done_cnt - d0), 1);
        check(arb_lost === 1'b0, "R10", "no arbitration loss", 32'(arb_lost), 0);
        check(bus_out === 1'b1, "R7", "recessive after frame", 32'(bus_out), 1);
    endtask

    task automatic wait_bits(int n);
        while (bits_seen < n) step();
    endtask

    task automatic lose_at(bit ext, bit rem, logic [28:0] id, int pos, string tag);
        int d0;
        launch(1'b0, ext, rem, id, 4'd2, 64'h1122_3344_5566_7788, 15'h1234);
        d0 = done_cnt;
        wait_bits(pos + 1);
        force_dom = 1'b1;
        repeat (6) step();
        check(arb_lost === 1'b1, tag, "arbitration lost flag", 32'(arb_lost), 1);
        check(busy === 1'b0, tag, "busy after loss", 32'(busy), 0);
        check(bus_out === 1'b1, tag, "recessive after loss", 32'(bus_out), 1);
        check(done_cnt - d0 == 1, tag, "done pulse on loss", 32'(done_cnt - d0), 1);
        repeat (12) step();
        check(bits_seen == pos + 1, tag, "no bits after loss", 32'(bits_seen), 32'(pos + 1));
        check(arb_lost === 1'b1, tag, "lost flag held", 32'(arb_lost), 1);
        force_dom = 1'b0;
        sb_on = 1'b1;
    endtask

    // Strobe generator and scoreboard monitor share one process so nothing races at the edge
    initial begin
        int  ph;
        bit  busy_prev;
        bit  e;
        ph = 0;
        busy_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (bit_tick && busy_prev) begin
                bits_seen++;
                if (sb_on) begin
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        check(bus_out === e, cur_tag, "serial bit (R8)", 32'(bus_out), 32'(e));
                    end else begin
                        check(done === 1'b1 && busy === 1'b0, "R7", "done and idle after trailer",
                              {30'd0, done, busy}, 32'h2);
                    end
                end
            end
            if (done) done_cnt++;
            busy_prev = busy;
            ph = (ph + 1) % 4;
            bit_tick = (ph == 0);
            sample_tick = (ph == 2);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();

        // R1 reset state
        check(bus_out === 1'b1, "R1", "bus_out after reset", 32'(bus_out), 1);
        check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(done === 1'b0, "R1", "done after reset", 32'(done), 0);
        check(arb_lost === 1'b0, "R1", "arb_lost after reset", 32'(arb_lost), 0);

        // R2 start ignored while the bus is not quiet
        bus_quiet = 1'b0;
        start = 1'b1;
        repeat (10) step();
        check(busy === 1'b0, "R2", "start while bus not quiet", 32'(busy), 0);
        check(bus_out === 1'b1, "R2", "output while refused", 32'(bus_out), 1);
        start = 1'b0;
        bus_quiet = 1'b1;
        step();

        cur_tag = "R3";
        launch(1'b1, 1'b0, 1'b0, 29'h123, 4'd2, 64'h1234_0000_0000_0000, 15'h2372);
        finish_frame();

        cur_tag = "R5";
        launch(1'b1, 1'b0, 1'b1, 29'h3E8, 4'd5, 64'hFFFF_FFFF_0000_0000, 15'h30BB);
        finish_frame();

        cur_tag = "R4";
        launch(1'b1, 1'b1, 1'b0, 29'h1ABC_DEF5, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h7B4A);
        finish_frame();

        cur_tag = "R6";
        launch(1'b1, 1'b0, 1'b0, 29'h000, 4'd15, 64'h00FF_00FF_F0F0_0000, 15'h7FFF);
        finish_frame();

        // R6: payload ends recessive, all-zero CRC forces a stuff bit after the last CRC bit
        cur_tag = "R6";
        launch(1'b1, 1'b0, 1'b0, 29'h2A5, 4'd1, 64'hA500_0000_0000_0000, 15'h0000);
        finish_frame();

        // R10: dominant bus on a dominant bit inside the span and after the span
        cur_tag = "R10";
        launch(1'b1, 1'b0, 1'b0, 29'h555, 4'd3, 64'hC3C3_C300_0000_0000, 15'h5A5A);
        wait_bits(3);
        force_dom = 1'b1;
        wait_bits(4);
        force_dom = 1'b0;
        wait_bits(14);
        force_dom = 1'b1;
        finish_frame();
        force_dom = 1'b0;

        // R9: loss at the first span position, at the last 11-bit position, and at an extended one
        lose_at(1'b0, 1'b0, 29'h555, 1, "R9");
        lose_at(1'b0, 1'b1, 29'h555, 12, "R9");
        lose_at(1'b1, 1'b0, 29'h0AAA_AAAA, 12, "R9");

        // R4 and R9: next frame after a loss clears the flag and runs to completion
        cur_tag = "R4";
        launch(1'b1, 1'b1, 1'b1, 29'h14D6_0246, 4'd3, 64'hDEAD_BEEF_0000_0000, 15'h5262);
        finish_frame();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule